// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is an 18-bit-wide synchronous static RAM that takes a new read or write command on every clock edge. No idle cycle is needed when traffic switches between reads and writes. A write names its address on one edge and supplies its data on a later edge, so the shared data path stays busy without gaps. The delay is one edge in flow-through mode and two edges in pipelined mode. A read that targets a word whose write data is still in flight returns the newer bytes, merged with the bytes already stored.

Commands are loaded with an address or continued as a four-beat burst. A burst walks the two lowest address bits in either linear or interleaved order. Three chip selects gate each load. Two inputs switch the output off without waiting for a clock edge: an output enable, and a sleep input that also makes the core ignore commands. The data-in and data-out ports are separate, and a valid flag replaces a tristate bus. The depth is set by an address-width parameter.

The mode inputs `pipe_mode` and `burst_ilv` are expected to change only while no burst or late write is in progress.

Top module: `late_write_sram`

## Requirements
- R1: While `rst` is high and after it is released, `dout_vld` is 0 and `dout` is 0. Every word of the array reads back as zero until it is written.
- R2: A read loaded at edge k drives `dout_vld`=1 with its word after edge k when `pipe_mode`=0, and after edge k+1 when `pipe_mode`=1. A four-beat read burst therefore delivers in 2-1-1-1 clocks in flow-through mode and 3-1-1-1 clocks in pipelined mode.
- R3: The data of a write command accepted at edge k is taken from `din` at edge k+1 when `pipe_mode`=0 and at edge k+2 when `pipe_mode`=1. The byte enables are taken with the command at edge k.
- R4: Any mix of reads and writes runs at one command per edge. A read returns the word as left by every write accepted before it, including writes whose data has not yet reached the array.
- R5: `byte_we[0]` enables bits 8:0 and `byte_we[1]` enables bits 17:9. A write leaves unselected bytes unchanged.
- R6: A load (`adv`=0) is accepted only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Otherwise the cycle is a deselect: nothing is written, `dout_vld` stays 0 in the slot where read data would have appeared, and late writes already accepted still complete.
- R7: With `adv`=1 after an accepted command, the burst steps to the next beat, keeps the operation of its load and uses the current `byte_we`. The chip selects are not examined on such a cycle. The low two address bits follow (start+beat) mod 4 when `burst_ilv`=0 and start XOR beat when `burst_ilv`=1, and the upper bits are held. `adv`=1 after a deselect is itself a deselect.
- R8: When `oe`=0, `dout_vld` and `dout` are 0 at once, without a clock edge. When `oe` returns to 1, the pending read result reappears.
- R9: While `sleep`=1, outputs are forced off at once and any command sampled is ignored as a deselect, which also ends a burst. Late writes already accepted still complete.
- R10: `dout` is 0 whenever `dout_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address for a load |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| wr_en | input | 1 | 1 = write, 0 = read (load cycles) |
| byte_we | input | 2 | Per-byte write enables |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through |
| burst_ilv | input | 1 | 1 = interleaved burst, 0 = linear |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| din | input | 18 | Late write data |
| dout | output | 18 | Read data |
| dout_vld | output | 1 | Read data valid |

## Verification
The core is exercised in both latency modes with:
- isolated writes followed by reads, which separate a wrong write delay from a wrong read delay;
- back-to-back read-write-read traffic on one address, which shows whether in-flight bytes are forwarded;
- partial byte writes, which expose byte lanes that are swapped or overwritten;
- linear and interleaved bursts from unaligned starts, which reveal wrong address ordering.

Loads with one chip select wrong at a time, sleep held across edges, and output-enable or sleep pulses inside a cycle distinguish ignored commands from asynchronously suppressed output.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int WORD_W    = 18;
    localparam int BYTE_W    = 9;
    localparam int NBYTES    = WORD_W / BYTE_W;
    localparam int BURST_W   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NBYTES-1:0] bmask_t;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

    typedef struct packed {
        logic   valid;
        logic   wr;
        bmask_t be;
    } cmd_t;

    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               ilv
    );
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

    function automatic word_t merge_bytes(
        input word_t  old_w,
        input word_t  new_w,
        input bmask_t be
    );
        word_t res;
        res = old_w;
        for (int i = 0; i < NBYTES; i++) begin
            if (be[i]) res[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/lws_cmd_ctrl.sv
module lws_cmd_ctrl
    import lws_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          adv,
    input  logic          wr_en,
    input  bmask_t        byte_we,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          sleep,
    input  logic          burst_ilv,
    output cmd_t          cmd_o,
    output logic [AW-1:0] cmd_addr_o
);

    logic                 burst_on;
    logic [AW-1:0]        base_q;
    logic [BURST_W-1:0]   beat_q;
    logic                 burst_wr_q;
    logic [BURST_W-1:0]   next_beat;
    logic                 chips_ok;
    logic                 do_load;
    logic                 do_step;

    assign chips_ok  = !cs0_n && cs1 && !cs2_n;
    assign do_load   = !sleep && !adv && chips_ok;
    assign do_step   = !sleep && adv && burst_on;
    assign next_beat = beat_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_on   <= 1'b0;
            base_q     <= '0;
            beat_q     <= '0;
            burst_wr_q <= 1'b0;
            cmd_o      <= '0;
            cmd_addr_o <= '0;
        end else if (do_load) begin
            burst_on   <= 1'b1;
            base_q     <= addr;
            beat_q     <= '0;
            burst_wr_q <= wr_en;
            cmd_o      <= '{valid: 1'b1, wr: wr_en, be: byte_we};
            cmd_addr_o <= addr;
        end else if (do_step) begin
            beat_q     <= next_beat;
            cmd_o      <= '{valid: 1'b1, wr: burst_wr_q, be: byte_we};
            cmd_addr_o <= {base_q[AW-1:BURST_W],
                           burst_low(base_q[BURST_W-1:0], next_beat, burst_ilv)};
        end else begin
            burst_on   <= 1'b0;
            cmd_o      <= '0;
        end
    end

endmodule

// File: rtl/lws_wr_pipe.sv
module lws_wr_pipe
    import lws_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  lat_mode_e     mode,
    input  cmd_t          cmd1,
    input  logic [AW-1:0] addr1,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output bmask_t        wr_be
);

    cmd_t          cmd2;
    logic [AW-1:0] addr2;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd2  <= '0;
            addr2 <= '0;
        end else begin
            cmd2  <= cmd1;
            addr2 <= addr1;
        end
    end

    always_comb begin
        if (mode == LAT_PIPE) begin
            wr_go   = cmd2.valid && cmd2.wr;
            wr_addr = addr2;
            wr_be   = cmd2.be;
        end else begin
            wr_go   = cmd1.valid && cmd1.wr;
            wr_addr = addr1;
            wr_be   = cmd1.be;
        end
    end

endmodule

// File: rtl/lws_mem_array.sv
module lws_mem_array
    import lws_pkg::*;
#(
    parameter int AW    = 4,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  bmask_t        wbe,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= merge_bytes(mem[waddr], wdata, wbe);
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/lws_read_out.sv
module lws_read_out
    import lws_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  lat_mode_e     mode,
    input  logic          oe,
    input  logic          sleep,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  word_t         mem_rdata,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  bmask_t        wr_be,
    input  word_t         din,
    output word_t         dout,
    output logic          dout_vld
);

    logic  fwd_hit;
    word_t fwd_word;
    logic  q_vld;
    word_t q_data;
    logic  src_vld;
    word_t src_data;

    assign fwd_hit  = wr_go && (wr_addr == rd_addr);
    assign fwd_word = fwd_hit ? merge_bytes(mem_rdata, din, wr_be) : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_data <= '0;
        end else begin
            q_vld  <= rd_req;
            q_data <= fwd_word;
        end
    end

    assign src_vld  = (mode == LAT_PIPE) ? q_vld  : rd_req;
    assign src_data = (mode == LAT_PIPE) ? q_data : mem_rdata;
    assign dout_vld = src_vld && oe && !sleep;
    assign dout     = dout_vld ? src_data : '0;

endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
    import lws_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          adv,
    input  logic          wr_en,
    input  logic [1:0]    byte_we,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          pipe_mode,
    input  logic          burst_ilv,
    input  logic          oe,
    input  logic          sleep,
    input  logic [17:0]   din,
    output logic [17:0]   dout,
    output logic          dout_vld
);

    localparam int DEPTH = 1 << AW;

    lat_mode_e     mode;
    cmd_t          cmd1;
    logic [AW-1:0] addr1;
    logic          wr_go;
    logic [AW-1:0] wr_addr;
    bmask_t        wr_be;
    word_t         mem_rdata;
    logic          rd_req;

    assign mode   = lat_mode_e'(pipe_mode);
    assign rd_req = cmd1.valid && !cmd1.wr;

    lws_cmd_ctrl #(.AW(AW)) u_cmd (
        .clk(clk), .rst(rst), .addr(addr), .adv(adv), .wr_en(wr_en),
        .byte_we(byte_we), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .sleep(sleep), .burst_ilv(burst_ilv),
        .cmd_o(cmd1), .cmd_addr_o(addr1)
    );

    lws_wr_pipe #(.AW(AW)) u_wpipe (
        .clk(clk), .rst(rst), .mode(mode), .cmd1(cmd1), .addr1(addr1),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be)
    );

    lws_mem_array #(.AW(AW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .we(wr_go), .waddr(wr_addr), .wbe(wr_be),
        .wdata(din), .raddr(addr1), .rdata(mem_rdata)
    );

    lws_read_out #(.AW(AW)) u_rd (
        .clk(clk), .rst(rst), .mode(mode), .oe(oe), .sleep(sleep),
        .rd_req(rd_req), .rd_addr(addr1), .mem_rdata(mem_rdata),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_be(wr_be), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

endmodule

// File: rtl/lws_checker.sv
module lws_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv,
    input logic        wr_en,
    input logic        cs0_n,
    input logic        cs1,
    input logic        cs2_n,
    input logic        pipe_mode,
    input logic        oe,
    input logic        sleep,
    input logic [17:0] dout,
    input logic        dout_vld
);

    logic [1:0] age;
    logic       rd_load;
    logic       bad_load;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign rd_load  = !sleep && !adv && !wr_en && !cs0_n && cs1 && !cs2_n;
    assign bad_load = !sleep && !adv && !(!cs0_n && cs1 && !cs2_n);

    always_comb begin
        p_oe_gate_r8:     assert (oe || !dout_vld);
        p_sleep_gate_r9:  assert (!sleep || !dout_vld);
        p_quiet_zero_r10: assert (dout_vld || dout == 18'd0);
    end

    p_flow_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !pipe_mode && $past(!pipe_mode) && $past(rd_load) && oe && !sleep)
        |-> dout_vld);

    p_pipe_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2)
         && $past(rd_load, 2) && oe && !sleep)
        |-> dout_vld);

    p_desel_flow_r6: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !pipe_mode && $past(!pipe_mode) && $past(bad_load))
        |-> !dout_vld);

    p_desel_pipe_r6: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2)
         && $past(bad_load, 2))
        |-> !dout_vld);

    p_sleep_flow_r9: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !pipe_mode && $past(!pipe_mode) && $past(sleep))
        |-> !dout_vld);

    p_sleep_pipe_r9: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2)
         && $past(sleep, 2))
        |-> !dout_vld);

endmodule

bind late_write_sram lws_checker u_chk (
    .clk(clk), .rst(rst), .adv(adv), .wr_en(wr_en), .cs0_n(cs0_n),
    .cs1(cs1), .cs2_n(cs2_n), .pipe_mode(pipe_mode), .oe(oe),
    .sleep(sleep), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/tb_late_write_sram.sv
module tb_late_write_sram;

    localparam int CLK_PER = 10;
    localparam int AW      = 4;
    localparam int DEPTH   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          adv, wr_en;
    logic [1:0]    byte_we;
    logic          cs0_n, cs1, cs2_n;
    logic          pipe_mode, burst_ilv, oe, sleep;
    logic [17:0]   din;
    logic [17:0]   dout;
    logic          dout_vld;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    late_write_sram #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .adv(adv), .wr_en(wr_en),
        .byte_we(byte_we), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .pipe_mode(pipe_mode), .burst_ilv(burst_ilv), .oe(oe), .sleep(sleep),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    // behavioural reference model
    typedef struct { int a; int be; int due; } wr_rec_t;
    typedef struct { int a; int show; } rd_rec_t;
    wr_rec_t wq[$];
    rd_rec_t rq[$];
    int  mem_m [DEPTH];
    int  cyc = 0;
    bit  b_on = 0;
    int  b_base = 0, b_beat = 0;
    bit  b_wr = 0;
    bit  exp_vld = 0;
    int  exp_data = 0;

    task automatic model_edge();
        int  lat;
        bit  cmd, cwr;
        int  ca;
        lat = pipe_mode ? 2 : 1;
        cmd = 0; cwr = 0; ca = 0;
        if (sleep) b_on = 0;
        else if (!adv) begin
            if (!cs0_n && cs1 && !cs2_n) begin
                b_on = 1; b_base = int'(addr); b_beat = 0; b_wr = wr_en;
                cmd = 1; cwr = wr_en; ca = int'(addr);
            end else b_on = 0;
        end else if (b_on) begin
            b_beat = (b_beat + 1) % 4;
            cmd = 1; cwr = b_wr;
            ca = (b_base & ~3) | (burst_ilv ? ((b_base & 3) ^ b_beat)
                                            : (((b_base & 3) + b_beat) % 4));
        end
        for (int i = 0; i < wq.size(); ) begin
            if (wq[i].due == cyc) begin
                if (wq[i].be & 1) mem_m[wq[i].a] = (mem_m[wq[i].a] & 'h3FE00) | (int'(din) & 'h1FF);
                if (wq[i].be & 2) mem_m[wq[i].a] = (mem_m[wq[i].a] & 'h001FF) | (int'(din) & 'h3FE00);
                wq.delete(i);
            end else i++;
        end
        if (cmd && cwr) wq.push_back('{a: ca, be: int'(byte_we), due: cyc + lat});
        else if (cmd) rq.push_back('{a: ca, show: cyc + lat - 1});
        exp_vld = 0;
        for (int i = 0; i < rq.size(); ) begin
            if (rq[i].show == cyc) begin
                exp_vld = 1; exp_data = mem_m[rq[i].a]; rq.delete(i);
            end else i++;
        end
    endtask

    task automatic compare(input string tag);
        bit ev;
        int ed;
        ev = exp_vld && oe && !sleep;
        ed = ev ? exp_data : 0;
        checks++;
        if (dout_vld !== ev || int'(dout) != ed) begin
            errors++;
            $display("FAIL %s cyc=%0d actual vld=%0b data=%05h expected vld=%0b data=%05h",
                     tag, cyc, dout_vld, dout, ev, ed);
        end
    endtask

    task automatic tick(input string tag);
        din = 18'((cyc * 40503 + 12345) ^ (cyc << 9));
        @(posedge clk);
        cyc++;
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic go_load(input bit w, input int a, input int be);
        cs0_n = 0; cs1 = 1; cs2_n = 0; adv = 0; wr_en = w;
        addr = AW'(a); byte_we = 2'(be);
    endtask

    task automatic go_adv(input int be);
        adv = 1; byte_we = 2'(be);
    endtask

    task automatic go_idle();
        cs0_n = 1; cs1 = 1; cs2_n = 0; adv = 0; wr_en = 0;
    endtask

    task automatic idle_n(input int n, input string tag);
        go_idle();
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; addr = '0; adv = 0; wr_en = 0; byte_we = 2'b11;
        cs0_n = 1; cs1 = 0; cs2_n = 1; pipe_mode = 0; burst_ilv = 0;
        oe = 1; sleep = 0; din = '0;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (dout_vld !== 1'b0 || dout !== 18'd0) begin
            errors++;
            $display("FAIL R1 reset actual vld=%0b data=%05h expected vld=0 data=00000", dout_vld, dout);
        end
        rst = 0;

        for (int m = 0; m < 2; m++) begin
            go_idle();
            pipe_mode = m[0];
            burst_ilv = 0;
            idle_n(3, "R10");

            if (m == 0) begin
                for (int a = 0; a < 4; a++) begin go_load(0, a, 3); tick("R1"); end
                idle_n(2, "R1");
            end

            // late write delay and byte lanes
            go_load(1, 5, 3); tick("R3");
            go_load(1, 6, 1); tick("R5");
            go_load(1, 7, 2); tick("R5");
            idle_n(2, "R3");
            go_load(0, 5, 3); tick("R3");
            go_load(0, 6, 3); tick("R5");
            go_load(0, 7, 3); tick("R5");
            idle_n(2, "R2");

            // back-to-back traffic with in-flight writes
            go_load(1, 9, 3);  tick("R4");
            go_load(0, 9, 3);  tick("R4");
            go_load(1, 9, 2);  tick("R4");
            go_load(0, 9, 3);  tick("R4");
            go_load(0, 10, 3); tick("R4");
            go_load(1, 10, 1); tick("R4");
            go_load(0, 10, 3); tick("R4");
            go_load(1, 11, 3); tick("R4");
            go_load(1, 11, 1); tick("R4");
            go_load(0, 11, 3); tick("R4");
            idle_n(2, "R4");

            // bursts: linear then interleaved
            go_load(1, 13, 3); tick("R7");
            for (int i = 0; i < 3; i++) begin go_adv(3); tick("R7"); end
            idle_n(2, "R7");
            go_load(0, 12, 3); tick("R2");
            for (int i = 0; i < 3; i++) begin go_adv(3); tick("R2"); end
            idle_n(2, "R7");
            burst_ilv = 1;
            go_load(0, 14, 3); tick("R7");
            for (int i = 0; i < 3; i++) begin go_adv(3); tick("R7"); end
            go_load(1, 2, 3); tick("R7");
            go_adv(1); tick("R7");
            go_adv(2); tick("R7");
            go_adv(3); tick("R7");
            go_load(0, 1, 3); tick("R7");
            for (int i = 0; i < 3; i++) begin go_adv(3); tick("R7"); end
            idle_n(2, "R7");
            burst_ilv = 0;
            go_idle(); go_adv(3); tick("R7");
            tick("R7");
            idle_n(2, "R7");

            // chip selects
            go_load(1, 4, 3); cs0_n = 1; tick("R6");
            go_load(1, 4, 3); cs1 = 0;   tick("R6");
            go_load(1, 4, 3); cs2_n = 1; tick("R6");
            go_load(0, 4, 3); cs1 = 0;   tick("R6");
            idle_n(2, "R6");
            go_load(0, 4, 3); tick("R6");
            idle_n(2, "R6");
            go_load(1, 8, 3); tick("R6");
            idle_n(3, "R6");
            go_load(0, 8, 3); tick("R6");
            idle_n(2, "R6");

            // sleep ignores commands, late writes finish
            go_load(1, 3, 3); sleep = 1; tick("R9");
            sleep = 0; idle_n(2, "R9");
            go_load(0, 3, 3); tick("R9");
            idle_n(2, "R9");
            go_load(1, 1, 3); tick("R9");
            sleep = 1; go_idle(); tick("R9"); tick("R9");
            sleep = 0;
            go_load(0, 1, 3); tick("R9");
            idle_n(2, "R9");
            go_load(0, 5, 3); sleep = 1; tick("R9");
            sleep = 0; idle_n(2, "R9");

            // asynchronous output gating inside a read slot
            go_load(0, 8, 3); tick("R8");
            if (m == 1) begin go_idle(); tick("R2"); end
            sleep = 1; #1; compare("R9");
            sleep = 0; #1; compare("R9");
            oe = 0;    #1; compare("R8");
            oe = 1;    #1; compare("R8");
            idle_n(3, "R10");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule